// File: doc/BRIEF.md
# Power-Management Command Port Pair

This block is an I/O-space slave with two byte registers at fixed port addresses. The command register sits at port 0xB2 and the parameter register at port 0xB3. When software writes the command port, the block raises a single-cycle request to the system-management interrupt logic. Before it does so, software can leave a parameter byte in the parameter register. The interrupt handler then reads both ports back to decide what to do.

The bus side has these signals:
- a port address
- a 16-bit write-data path split into two byte lanes, with a byte enable for each lane
- a write strobe and a read strobe

Lane 0 carries port 0xB2 and lane 1 carries port 0xB3. A single 16-bit write at 0xB2 therefore loads both registers in one access. Writing the parameter port alone never raises the request, so software can pass data through it freely.

Top module: `apm_port_pair`

## Requirements
- R1: After reset both registers read 0x00 and the request output is low.
- R2: An access hits the pair when address bits [15:1] equal 0x59. With address bit 0 clear, byte enable bit 0 selects the command register (lane 0, data bits [7:0]) and byte enable bit 1 selects the parameter register (lane 1, data bits [15:8]). With address bit 0 set (port 0xB3), only lane 1 is reachable and byte enable bit 0 is ignored.
- R3: A write that enables the command lane loads the register at the clock edge of the write. The request output is high for exactly the following cycle, and the command register already holds the new byte during that cycle.
- R4: A write that reaches only the parameter lane updates the parameter register and leaves the request output low.
- R5: A 16-bit write at 0xB2 with both enables set loads data bits [7:0] into the command register and bits [15:8] into the parameter register. It raises exactly one request pulse.
- R6: A read of 0xB2 returns exactly the byte last written there. Neither register changes unless its lane is written.
- R7: Reads have no side effects: a cycle without a command-lane write is followed by a low request output.
- R8: Accesses to any other address are ignored: no register changes, no request, and read data is zero.
- R9: Read data carries a register's byte only in an enabled, reachable lane while the read strobe is high. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 16 | Write data, lane 0 in [7:0], lane 1 in [15:8] |
| io_be_i | input | 2 | Byte-lane enables |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_rdata_o | output | 16 | Read data, zero outside a hit read |
| smi_req_o | output | 1 | One-cycle interrupt request after a command write |

## Verification
The bench writes every byte value to the command port and checks three things each time:
- the pulse appears only in the cycle after the write, so a design that fired on the write edge or held the pulse would be caught;
- the pulse sees the new value, so a design that pulsed before the register updated would be caught;
- the register reads back exactly.

It also sweeps every byte value through the parameter port, using both addressing forms. This catches a decoder that lets parameter writes fire the request, and one that honours lane 0 at the odd address. Wide writes check that a single pulse comes with the correct byte split. A sweep over the 512 lowest port addresses catches aliasing or a stray update: each address is written, then read, and the pair is read back afterwards to confirm nothing moved.

// File: rtl/apm_port_pkg.sv
package apm_port_pkg;
  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned CMD_PORT = 'hB2;  // lane 0; lane 1 is CMD_PORT+1
  localparam int unsigned CMD_LANE = 0;
endpackage

// File: rtl/apm_decode.sv
module apm_decode #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [apm_port_pkg::LANES-1:0]   be_i,
  input  logic                             wr_i,
  input  logic                             rd_i,
  output logic                             hit_o,
  output logic [apm_port_pkg::LANES-1:0]   lane_wr_o,
  output logic [apm_port_pkg::LANES-1:0]   lane_rd_o
);
  import apm_port_pkg::*;
  localparam int unsigned WORD_W = ADDR_W - 1;
  localparam logic [WORD_W-1:0] WORD_ADDR = WORD_W'(CMD_PORT >> 1);

  logic [LANES-1:0] lane_en;

  assign hit_o = (addr_i[ADDR_W-1:1] == WORD_ADDR);
  // odd address reaches only the upper lane
  assign lane_en   = addr_i[0] ? (be_i & {{(LANES-1){1'b1}}, 1'b0}) : be_i;
  assign lane_wr_o = (hit_o && wr_i) ? lane_en : '0;
  assign lane_rd_o = (hit_o && rd_i) ? lane_en : '0;
endmodule

// File: rtl/apm_byte_reg.sv
module apm_byte_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R6
endmodule

// File: rtl/apm_smi_pulse.sv
module apm_smi_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic smi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_o <= 1'b0;
    else         smi_o <= fire_i;
  end

  AST_NO_FIRE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !smi_o); // R7
endmodule

// File: rtl/apm_port_pair.sv
module apm_port_pair #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic [15:0]           io_wdata_i,
  input  logic [1:0]            io_be_i,
  input  logic                  io_wr_i,
  input  logic                  io_rd_i,
  output logic [15:0]           io_rdata_o,
  output logic                  smi_req_o
);
  import apm_port_pkg::*;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic             hit;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;
  logic [LANE_W-1:0] lane_q [LANES];

  apm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (io_addr_i),
    .be_i      (io_be_i),
    .wr_i      (io_wr_i),
    .rd_i      (io_rd_i),
    .hit_o     (hit),
    .lane_wr_o (lane_wr),
    .lane_rd_o (lane_rd)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    apm_byte_reg #(.W(LANE_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (lane_wr[i]),
      .d_i    (io_wdata_i[i*LANE_W +: LANE_W]),
      .q_o    (lane_q[i])
    );
    assign io_rdata_o[i*LANE_W +: LANE_W] = lane_rd[i] ? lane_q[i] : '0;
  end

  apm_smi_pulse u_smi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (lane_wr[CMD_LANE]),
    .smi_o  (smi_req_o)
  );

  AST_SMI_ON_CMD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && !io_addr_i[0] && io_be_i[0]) |=> smi_req_o); // R3
  AST_SMI_SEES_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && !io_addr_i[0] && io_be_i[0])
      |=> (lane_q[CMD_LANE] == $past(io_wdata_i[7:0]))); // R3
  AST_PARAM_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && (io_addr_i[0] || io_be_i == 2'b10)) |=> !smi_req_o); // R4
  AST_WIDE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && hit && !io_addr_i[0] && io_be_i == 2'b11)
      |=> (lane_q[1] == $past(io_wdata_i[15:8]))); // R5
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !smi_req_o); // R8
  AST_MISS_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit || !io_rd_i) |-> io_rdata_o == DATA_W'(0)); // R9
endmodule

// File: tb/apm_port_pair_tb.sv
module apm_port_pair_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [15:0] io_wdata_i = '0;
  logic [1:0]  io_be_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [15:0] io_rdata_o;
  logic        smi_req_o;

  int n_chk = 0;
  int n_fail = 0;

  apm_port_pair u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write; sample request in the cycle after the edge and the one after that
  task automatic do_wr(input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit exp_smi, input string tag);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_be_i = be; io_wr_i = 1'b1;
    #2 check(smi_req_o == 1'b0, {tag, " pre-edge"}, 16'(smi_req_o), 16'h0);
    @(negedge clk_i);
    io_wr_i = 1'b0;
    #1 check(smi_req_o == exp_smi, tag, 16'(smi_req_o), 16'(exp_smi));
    @(negedge clk_i);
    #1 check(smi_req_o == 1'b0, {tag, " pulse end"}, 16'(smi_req_o), 16'h0);
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [1:0] be,
                       input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    io_addr_i = a; io_be_i = be; io_rd_i = 1'b1;
    #2 check(io_rdata_o == exp, tag, io_rdata_o, exp);
    @(negedge clk_i);
    io_rd_i = 1'b0;
    #1 check(smi_req_o == 1'b0, "R7 read quiet", 16'(smi_req_o), 16'h0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cmd_m, sts_m;
    #35 rst_ni = 1'b1;
    #1 check(smi_req_o == 1'b0, "R1 reset smi", 16'(smi_req_o), 16'h0);
    do_rd(16'h00B2, 2'b11, 16'h0000, "R1 reset regs");

    // R3/R6: every command byte
    cmd_m = 16'h0000; sts_m = 16'h0000;
    for (int v = 0; v < 256; v++) begin
      do_wr(16'h00B2, {8'h5A, 8'(v)}, 2'b01, 1'b1, "R3 cmd write");
      cmd_m = 16'(v);
      do_rd(16'h00B2, 2'b01, cmd_m, "R6 cmd readback");
    end
    do_rd(16'h00B2, 2'b10, 16'h0000, "R9 lane1 only, param untouched");

    // R4: every parameter byte, both addressing forms
    for (int v = 0; v < 256; v++) begin
      if (v[0]) do_wr(16'h00B3, {8'(v), 8'hC3}, 2'b11, 1'b0, "R4 param write odd");
      else      do_wr(16'h00B2, {8'(v), 8'hC3}, 2'b10, 1'b0, "R4 param write lane1");
      sts_m = 16'(v);
      do_rd(16'h00B2, 2'b11, {sts_m[7:0], cmd_m[7:0]}, "R4 pair readback");
    end
    do_rd(16'h00B3, 2'b11, {sts_m[7:0], 8'h00}, "R2 odd read lane1 only");
    do_rd(16'h00B2, 2'b00, 16'h0000, "R9 no enables");

    // R5: wide writes
    for (int v = 0; v < 64; v++) begin
      logic [15:0] d;
      d = 16'((v * 16'h2F1B) ^ 16'hA55A);
      do_wr(16'h00B2, d, 2'b11, 1'b1, "R5 wide write");
      cmd_m = {8'h00, d[7:0]}; sts_m = {8'h00, d[15:8]};
      do_rd(16'h00B2, 2'b11, d, "R5 wide readback");
    end

    // R8: miss sweep
    for (int a = 0; a < 512; a++) begin
      if (a == 'hB2 || a == 'hB3) continue;
      do_wr(16'(a), 16'(~a), 2'b11, 1'b0, "R8 miss write");
      do_rd(16'(a), 2'b11, 16'h0000, "R8 miss read");
    end
    do_wr(16'h80B2, 16'h1234, 2'b11, 1'b0, "R8 high alias");
    do_rd(16'h00B2, 2'b11, {sts_m[7:0], cmd_m[7:0]}, "R8 pair unchanged");

    // R1: asynchronous reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    #2 check(io_rdata_o == 16'h0 && smi_req_o == 1'b0, "R1 async reset",
             {15'h0, smi_req_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    do_rd(16'h00B2, 2'b11, 16'h0000, "R1 regs cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule